// File: doc/BRIEF.md
# Critical-Word-First Burst Memory Target

This block is the memory side of a split request/response bus. It holds a small array of 64-bit words and serves one transaction at a time. A transaction is a load or a store of a single word, a two-word (16-byte) burst, or a four-word (32-byte) burst. A new request is taken only after the response of the previous one has fully left the block.

The request address of a burst names the word that is transferred first, not the start of the aligned block. Beats run upward from that word and wrap around inside the aligned two- or four-word block. The same rotated order applies to store data flowing in and to load data flowing out.

Each response beat returns the transaction ID of its request unchanged. A store is answered by one acknowledge beat, and only after every one of its data beats has been written into the array. All three channels (request, store data, response) move a beat only on a cycle where valid and ready are both high.

Top module: `cwf_burst_target`

## Requirements
- R1: While reset is asserted and right after it is released, req_ready is 1, while rsp_valid and wr_ready are 0.
- R2: req_ready is 1 only while no transaction is pending. A request presented while one is pending is not taken and changes neither the IDs nor the data of the responses in flight.
- R3: A load with req_size 2'b00 returns one beat holding word req_addr[ADDR_W-1:3], with rsp_last set.
- R4: A load with req_size 2'b01 returns two beats. If address bit 3 is 0, the words come in block order 0,1. If it is 1, they come as 1,0. The block is the address with bits 3:0 cleared.
- R5: A load with req_size 2'b10 returns four beats. Address bits 4:3 give the word order: 00→0,1,2,3; 01→1,2,3,0; 10→2,3,0,1; 11→3,0,1,2. The block is the address with bits 4:0 cleared. rsp_last is set on the fourth beat only.
- R6: The data beats of a store are written in the same address-derived order as in R4 and R5. The first beat goes to the addressed word.
- R7: A store is answered by exactly one beat with rsp_last=1 and rsp_data=0. The beat appears only after all of the store's data beats have been accepted.
- R8: Every response beat carries rsp_id equal to the req_id of the request being served.
- R9: While rsp_valid=1 and rsp_ready=0, rsp_valid, rsp_data, rsp_id and rsp_last hold their values into the next cycle.
- R10: rsp_valid is never 1 without a pending transaction. After the last response beat is taken, the block is idle again with rsp_valid=0.
- R11: Address bits 2:0 have no effect on word selection. req_size 2'b11 behaves as a four-word burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | 00 single word, 01 two-word burst, 10/11 four-word burst |
| req_addr | input | ADDR_W | Byte address of the first word transferred |
| req_id | input | ID_W | Transaction ID |
| wr_valid | input | 1 | Store data beat present |
| wr_ready | output | 1 | Store data beat can be taken |
| wr_data | input | DATA_W | Store data beat |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Response beat consumed |
| rsp_data | output | DATA_W | Load data, zero on a store acknowledge |
| rsp_id | output | ID_W | Echoed transaction ID |
| rsp_last | output | 1 | Final beat of the response |

## Verification
The bench builds the block with ADDR_W=7 and ID_W=6. This gives sixteen words, four aligned four-word blocks and eight two-word blocks. Random addresses therefore hit every rotation of every block many times, including the wrap from the top word of a block back to its base, and the full array fits in a short pre-fill. A six-bit ID space lets random IDs, and the complemented IDs of requests held off during a busy period, be told apart from the ID being echoed.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WDATA = 2'd1,
    ST_WACK  = 2'd2,
    ST_RDATA = 2'd3
  } cwf_state_e;

  localparam logic [1:0] SZ_ONE  = 2'b00;
  localparam logic [1:0] SZ_TWO  = 2'b01;

  // Low word-index bits that rotate inside the burst block.
  function automatic logic [1:0] size_mask(input logic [1:0] sz);
    logic [1:0] m;
    if (sz == SZ_ONE)      m = 2'b00;
    else if (sz == SZ_TWO) m = 2'b01;
    else                   m = 2'b11;
    return m;
  endfunction

endpackage

// File: rtl/cwf_beat_map.sv
module cwf_beat_map #(
  parameter int WIW = 4
) (
  input  logic [WIW-1:0] base_idx,
  input  logic [1:0]     crit,
  input  logic [1:0]     mask,
  input  logic [1:0]     beat,
  output logic [WIW-1:0] word_idx
);

  logic [1:0] off;

  always_comb begin
    off      = (crit + beat) & mask;
    word_idx = base_idx | WIW'(off);
  end

endmodule

// File: rtl/cwf_word_store.sv
module cwf_word_store #(
  parameter int WIW    = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [WIW-1:0]    waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [WIW-1:0]    raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << WIW;

  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = we && (waddr == WIW'(g));
    always_ff @(posedge clk) begin
      if (hit) word_q[g] <= wdata;
    end
  end

  assign rdata = word_q[raddr];

endmodule

// File: rtl/cwf_ctrl.sv
module cwf_ctrl
  import cwf_pkg::*;
#(
  parameter int WIW  = 4,
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [1:0]      req_size,
  input  logic [WIW-1:0]  req_widx,
  input  logic [ID_W-1:0] req_id,
  input  logic            wr_valid,
  input  logic            rsp_ready,
  output logic            req_ready,
  output logic            wr_ready,
  output logic            rsp_valid,
  output logic            rsp_last,
  output logic            rsp_is_load,
  output logic            mem_we,
  output logic [WIW-1:0]  cur_base,
  output logic [1:0]      cur_crit,
  output logic [1:0]      cur_mask,
  output logic [1:0]      cur_beat,
  output logic [ID_W-1:0] cur_id
);

  cwf_state_e state_q, state_d;
  logic [WIW-1:0]  base_q, base_d;
  logic [1:0]      crit_q, crit_d;
  logic [1:0]      mask_q, mask_d;
  logic [1:0]      beat_q, beat_d;
  logic [ID_W-1:0] id_q, id_d;
  logic            take_req, beat_en, at_last;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    take_req = (state_q == ST_IDLE) && req_valid;
    at_last  = (beat_q == mask_q);
    beat_en  = 1'b0;
    mask_d   = size_mask(req_size);
    crit_d   = req_widx[1:0] & mask_d;
    base_d   = req_widx & ~WIW'(mask_d);
    id_d     = req_id;
    beat_d   = beat_q + 2'd1;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = req_write ? ST_WDATA : ST_RDATA;
          beat_en = 1'b1;
          beat_d  = 2'd0;
        end
      end
      ST_WDATA: begin
        if (wr_valid) begin
          beat_en = 1'b1;
          if (at_last) state_d = ST_WACK;
        end
      end
      ST_WACK: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      ST_RDATA: begin
        if (rsp_ready) begin
          beat_en = 1'b1;
          if (at_last) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      crit_q  <= '0;
      mask_q  <= '0;
      beat_q  <= '0;
      id_q    <= '0;
    end else begin
      state_q <= state_d;
      if (take_req) begin
        base_q <= base_d;
        crit_q <= crit_d;
        mask_q <= mask_d;
        id_q   <= id_d;
      end
      if (beat_en) beat_q <= beat_d;
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign wr_ready    = (state_q == ST_WDATA);
  assign rsp_is_load = (state_q == ST_RDATA);
  assign rsp_valid   = (state_q == ST_RDATA) || (state_q == ST_WACK);
  assign rsp_last    = (state_q == ST_WACK) || ((state_q == ST_RDATA) && at_last);
  assign mem_we      = (state_q == ST_WDATA) && wr_valid;
  assign cur_base    = base_q;
  assign cur_crit    = crit_q;
  assign cur_mask    = mask_q;
  assign cur_beat    = beat_q;
  assign cur_id      = id_q;

endmodule

// File: rtl/cwf_burst_target.sv
module cwf_burst_target #(
  parameter int ADDR_W = 7,
  parameter int ID_W   = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ID_W-1:0]   rsp_id,
  output logic              rsp_last
);

  localparam int WIW = ADDR_W - 3;

  logic [WIW-1:0]    req_widx, cur_base, word_idx;
  logic [1:0]        cur_crit, cur_mask, cur_beat;
  logic              rsp_is_load, mem_we;
  logic [DATA_W-1:0] mem_rdata;

  assign req_widx = req_addr[ADDR_W-1:3];

  cwf_ctrl #(.WIW(WIW), .ID_W(ID_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_widx   (req_widx),
    .req_id     (req_id),
    .wr_valid   (wr_valid),
    .rsp_ready  (rsp_ready),
    .req_ready  (req_ready),
    .wr_ready   (wr_ready),
    .rsp_valid  (rsp_valid),
    .rsp_last   (rsp_last),
    .rsp_is_load(rsp_is_load),
    .mem_we     (mem_we),
    .cur_base   (cur_base),
    .cur_crit   (cur_crit),
    .cur_mask   (cur_mask),
    .cur_beat   (cur_beat),
    .cur_id     (rsp_id)
  );

  cwf_beat_map #(.WIW(WIW)) u_map (
    .base_idx(cur_base),
    .crit    (cur_crit),
    .mask    (cur_mask),
    .beat    (cur_beat),
    .word_idx(word_idx)
  );

  cwf_word_store #(.WIW(WIW), .DATA_W(DATA_W)) u_store (
    .clk  (clk),
    .we   (mem_we),
    .waddr(word_idx),
    .wdata(wr_data),
    .raddr(word_idx),
    .rdata(mem_rdata)
  );

  assign rsp_data = rsp_is_load ? mem_rdata : '0;

endmodule

// File: rtl/cwf_burst_target_chk.sv
module cwf_burst_target_chk #(
  parameter int ADDR_W = 7,
  parameter int ID_W   = 4,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic [ID_W-1:0]   req_id,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [ID_W-1:0]   rsp_id,
  input logic              rsp_last
);

  logic [ID_W-1:0] cap_id;
  logic            cap_wr;
  logic [1:0]      cap_last;
  logic [1:0]      rsp_n;
  logic [2:0]      wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_id   <= '0;
      cap_wr   <= 1'b0;
      cap_last <= '0;
      rsp_n    <= '0;
      wr_n     <= '0;
    end else if (req_valid && req_ready) begin
      cap_id   <= req_id;
      cap_wr   <= req_write;
      cap_last <= (req_size == 2'b00) ? 2'd0 : (req_size == 2'b01) ? 2'd1 : 2'd3;
      rsp_n    <= '0;
      wr_n     <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_n <= rsp_n + 2'd1;
      if (wr_valid && wr_ready)   wr_n  <= wr_n + 3'd1;
    end
  end

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !wr_ready));

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_data) && $stable(rsp_id) && $stable(rsp_last)));

  a_r8_id_echo: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_id == cap_id));

  a_r7_ack_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && cap_wr) |-> (rsp_last && (wr_n == ({1'b0, cap_last} + 3'd1))));

  a_r5_last_on_final: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !cap_wr) |-> (rsp_last == (rsp_n == cap_last)));

  a_r2_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && rsp_last) |=> req_ready);

endmodule

bind cwf_burst_target cwf_burst_target_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_size (req_size),
  .req_id   (req_id),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .rsp_id   (rsp_id),
  .rsp_last (rsp_last)
);

// File: tb/sim_cwf_burst_target.sv
module sim_cwf_burst_target;
  localparam int AW = 7;
  localparam int IW = 6;
  localparam int DW = 64;
  localparam int NW = 1 << (AW - 3);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic [IW-1:0] req_id;
  logic          wr_valid, wr_ready;
  logic [DW-1:0] wr_data;
  logic          rsp_valid, rsp_ready, rsp_last;
  logic [DW-1:0] rsp_data;
  logic [IW-1:0] rsp_id;

  int errs = 0;
  int checks = 0;
  logic [DW-1:0] model [NW];

  always #10 clk = ~clk;

  cwf_burst_target #(.ADDR_W(AW), .ID_W(IW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_id(req_id),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_id(rsp_id), .rsp_last(rsp_last)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int size_mask_tb(input logic [1:0] sz);
    return (sz == 2'b00) ? 0 : (sz == 2'b01) ? 1 : 3;
  endfunction

  // word index of beat k, from the ordering rules (R4, R5, R11)
  function automatic int beat_word(input int k, input logic [AW-1:0] a,
                                   input logic [1:0] sz);
    int w, m;
    w = int'(a[AW-1:3]);
    m = size_mask_tb(sz);
    return (w & ~m) | ((w + k) & m);
  endfunction

  task automatic send_req(input bit wr, input logic [1:0] sz,
                          input logic [AW-1:0] a, input logic [IW-1:0] id);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_id = id;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_data(input logic [AW-1:0] a, input logic [1:0] sz,
                           input logic [DW-1:0] d [4]);
    int n, k;
    n = size_mask_tb(sz) + 1;
    k = 0;
    while (k < n) begin
      if (k > 0 || wr_valid) @(negedge clk);
      chk(!rsp_valid, "R7 ack before data done", DW'(rsp_valid), '0);
      if ($urandom % 4 == 0) begin
        wr_valid = 1'b0;
        @(negedge clk);
      end
      wr_valid = 1'b1;
      wr_data  = d[k];
      while (!wr_ready) @(negedge clk);
      model[beat_word(k, a, sz)] = d[k];
      k++;
      @(posedge clk);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic get_rsp(input bit wr, input logic [AW-1:0] a, input logic [1:0] sz,
                         input logic [IW-1:0] id, input bit junk, input string tag);
    int n, k;
    bit held, r;
    logic [DW-1:0] pd, ed;
    logic [IW-1:0] pid;
    string t;
    n = wr ? 1 : size_mask_tb(sz) + 1;
    k = 0;
    held = 0;
    t = (tag != "") ? tag : wr ? "R7" : (sz == 2'b00) ? "R3" : (sz == 2'b01) ? "R4" : "R5";
    if (junk) begin
      req_valid = 1'b1; req_id = ~id; req_addr = AW'($urandom); req_write = $urandom;
    end
    while (k < n) begin
      @(negedge clk);
      r = ($urandom % 3) != 0;
      rsp_ready = r;
      if (held) begin
        chk(rsp_valid && rsp_data == pd && rsp_id == pid, "R9 hold while stalled",
            rsp_data, pd);
        held = 0;
      end
      if (junk) chk(!req_ready, "R2 busy ready low", DW'(req_ready), '0);
      if (rsp_valid) begin
        chk(rsp_id == id, "R8 id echo", DW'(rsp_id), DW'(id));
        chk(rsp_last == (k == n - 1), {t, " last flag"}, DW'(rsp_last), DW'(k == n - 1));
        ed = wr ? '0 : model[beat_word(k, a, sz)];
        chk(rsp_data == ed, {t, " beat data"}, rsp_data, ed);
        if (r) begin
          k++;
          if (k == n && junk) req_valid = 1'b0;
        end else begin
          held = 1; pd = rsp_data; pid = rsp_id;
        end
      end
    end
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !rsp_valid, "R10 idle after last", DW'(rsp_valid), '0);
  endtask

  task automatic do_store(input logic [1:0] sz, input logic [AW-1:0] a,
                          input logic [IW-1:0] id, input logic [DW-1:0] d [4]);
    send_req(1'b1, sz, a, id);
    send_data(a, sz, d);
    get_rsp(1'b1, a, sz, id, 1'b0, "");
  endtask

  task automatic do_load(input logic [1:0] sz, input logic [AW-1:0] a,
                         input logic [IW-1:0] id, input bit junk, input string tag);
    send_req(1'b0, sz, a, id);
    get_rsp(1'b0, a, sz, id, junk, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] d [4];
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = '0;
    req_addr = '0; req_id = '0; wr_valid = 1'b0; wr_data = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !wr_ready, "R1 reset state", DW'(rsp_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !wr_ready, "R1 after release", DW'(rsp_valid), '0);
    repeat (3) begin
      @(negedge clk);
      chk(!rsp_valid, "R10 idle no response", DW'(rsp_valid), '0);
    end

    // pre-fill every word with single stores
    for (int w = 0; w < NW; w++) begin
      d[0] = {$urandom, $urandom};
      do_store(2'b00, AW'(w << 3), IW'(w), d);
    end

    // directed: every rotation of a four-word and two-word load
    for (int c = 0; c < 4; c++) do_load(2'b10, AW'(32 + c * 8), IW'(c + 9), 1'b0, "R5");
    for (int c = 0; c < 2; c++) do_load(2'b01, AW'(16 + c * 8), IW'(c + 3), 1'b0, "R4");

    // directed R6: four-word store starting at word 2 of block 1, read back singly
    for (int k = 0; k < 4; k++) d[k] = 64'hA000_0000_0000_0000 | 64'(k);
    do_store(2'b10, AW'(32 + 16), IW'(21), d);
    for (int w = 0; w < 4; w++) begin
      do_load(2'b00, AW'(32 + w * 8), IW'(w), 1'b0, "R6");
      chk(model[4 + w] == (64'hA000_0000_0000_0000 | 64'((w + 2) & 3)),
          "R6 rotated store layout", model[4 + w],
          64'hA000_0000_0000_0000 | 64'((w + 2) & 3));
    end

    // directed R11: low address bits and size code 11
    do_load(2'b11, AW'(8 * 7 + 5), IW'(33), 1'b0, "R11");
    do_load(2'b01, AW'(8 * 3 + 7), IW'(34), 1'b0, "R11");

    // directed R2: requests held during a busy load
    do_load(2'b10, AW'(8 * 13), IW'(7), 1'b1, "R2");
    do_load(2'b00, AW'(8 * 13), IW'(8), 1'b0, "R2");

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      logic [1:0] sz;
      logic [AW-1:0] a;
      logic [IW-1:0] id;
      sz = $urandom % 3;
      if ($urandom % 8 == 0) sz = 2'b11;
      a = AW'($urandom);
      id = IW'($urandom);
      if ($urandom % 2 == 0) begin
        for (int k = 0; k < 4; k++) d[k] = {$urandom, $urandom};
        do_store(sz, a, id, d);
      end else begin
        do_load(sz, a, id, ($urandom % 6) == 0, "");
      end
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule